// File: doc/BRIEF.md
# Offset-Header Wormhole Mesh Router

This block is one router node of a two-dimensional mesh. It has five ports: local, north, east, south and west. Each port has a flit-wide valid/ready input channel and a matching output channel. A packet is a head flit, then any number of body flits, then a tail flit. The head does not carry an absolute destination. It carries two small signed hop counts, one for the X dimension and one for the Y dimension.

At every node the router first drives the X count to zero and only then the Y count, in dimension order. It takes one step off the count it is correcting and sends the head out of the matching neighbour port. When both counts are zero, the packet goes to the local port. Because the header is rewritten on every hop, the check word in the tail flit is regenerated on the way out. It is computed over the flits as they actually leave the node.

Once a head has won an output, the packet occupies that output until its tail has passed (wormhole switching). Heads that compete for a free output are chosen by a round-robin arbiter owned by that output. The datapath is combinational from input to output. A flit moves in the same cycle as the handshake, and there is no storage inside the node other than the lock, owner, pointer and check-word registers of each output.

Top module: `mesh_router`

## Requirements
- R1: After reset, with every input valid low, every output valid and every input ready is low.
- R2: A head whose X count is positive leaves on the east port (index 2) with X reduced by one. A head whose X count is negative leaves on the west port (index 4) with X raised by one. Y is unchanged in both cases.
- R3: A head with X equal to zero and a positive Y leaves on the north port (index 1) with Y reduced by one. With a negative Y it leaves on the south port (index 3) with Y raised by one.
- R4: A head with both counts zero leaves on the local port (index 0) with its header unchanged.
- R5: Body and tail flits follow their head's output. While a packet holds an output, heads from other inputs that want that output see input ready low. The output is released in the cycle after the tail transfers.
- R6: On the way out, the data field bits [15:0] of each tail flit are replaced by a CRC-16. The CRC uses polynomial 0x1021, seed 0xFFFF and MSB-first order, and runs over bits [15:0] of the outgoing (rewritten) head and of every body flit of that packet, in the order they leave.
- R7: When several heads request the same free output in one cycle, the winner is the lowest input index at or after that output's pointer, wrapping from 4 to 0. After each accepted head the pointer moves to one past the winner. The pointer is 0 after reset.
- R8: A flit is 18 bits. Bits [17:16] give the kind: 01 head, 00 body, 10 tail. In a head, X is bits [7:4] and Y is bits [3:0], each 4-bit two's complement. Head bits [15:8] pass through unchanged.
- R9: A flit transfers only when the output's ready is high. While it is low, the matching input ready stays low, the output flit holds, and the check word is not advanced.
- R10: Packets that go to different outputs move in the same cycle, independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 5 | Per-input flit valid (bit = port index) |
| in_flit | input | 5x18 | Per-input flit |
| in_ready | output | 5 | Per-input ready |
| out_valid | output | 5 | Per-output flit valid |
| out_flit | output | 5x18 | Per-output flit, header and tail rewritten |
| out_ready | input | 5 | Per-output ready from the downstream node |

## Verification
The bench drives headers at the extreme counts (-8, +3, +1, -1, 0). A router that compared with the wrong sign, or that stepped Y while X was still nonzero, would send such a head to a wrong port or rewrite the wrong field. A packet that is stalled on its head has its tail check word compared against a CRC over the head alone: a design that advanced the CRC during stalled cycles, or that hashed the incoming header instead of the rewritten one, would emit a wrong tail. Competing heads are raised while another packet holds the output and again after the pointer has reached the last index. A router that let a head cut into a live packet, or that failed to wrap its pointer, would grant the wrong input.

// File: rtl/mesh_router_pkg.sv
package mesh_router_pkg;

   localparam int NUM_PORTS = 5;
   localparam int CRC_W     = 16;
   localparam int KIND_W    = 2;

   localparam int PORT_LOCAL = 0;
   localparam int PORT_N     = 1;
   localparam int PORT_E     = 2;
   localparam int PORT_S     = 3;
   localparam int PORT_W     = 4;

   typedef enum logic [KIND_W-1:0] {
      FK_BODY = 2'b00,
      FK_HEAD = 2'b01,
      FK_TAIL = 2'b10,
      FK_RSVD = 2'b11
   } flit_kind_e;

   // One CRC word step, MSB first, over a 16-bit chunk.
   function automatic logic [CRC_W-1:0] crc_chunk(
      input logic [CRC_W-1:0] seed,
      input logic [CRC_W-1:0] chunk,
      input logic [CRC_W-1:0] poly);
      logic [CRC_W-1:0] acc;
      logic             fb;
      acc = seed;
      for (int b = CRC_W - 1; b >= 0; b--) begin
         fb  = acc[CRC_W-1] ^ chunk[b];
         acc = {acc[CRC_W-2:0], 1'b0};
         if (fb) acc = acc ^ poly;
      end
      return acc;
   endfunction

endpackage

// File: rtl/mr_route_calc.sv
module mr_route_calc
   import mesh_router_pkg::*;
#(
   parameter int FLIT_W = 18,
   parameter int OFF_W  = 4
)(
   input  logic [FLIT_W-1:0]    flit_i,
   output logic [NUM_PORTS-1:0] dest_oh_o,
   output logic [FLIT_W-1:0]    flit_o
);
   localparam int X_LO = OFF_W;
   localparam int X_HI = 2 * OFF_W - 1;
   localparam int Y_HI = OFF_W - 1;

   logic [OFF_W-1:0] x_cur, y_cur;
   logic             x_pos, x_neg, y_pos, y_neg;
   flit_kind_e       kind;

   assign kind  = flit_kind_e'(flit_i[FLIT_W-1 -: KIND_W]);
   assign x_cur = flit_i[X_HI:X_LO];
   assign y_cur = flit_i[Y_HI:0];
   assign x_neg = x_cur[OFF_W-1];
   assign x_pos = !x_cur[OFF_W-1] && (x_cur != '0);
   assign y_neg = y_cur[OFF_W-1];
   assign y_pos = !y_cur[OFF_W-1] && (y_cur != '0);

   always_comb begin
      dest_oh_o = '0;
      flit_o    = flit_i;
      if (x_pos) begin
         dest_oh_o[PORT_E]  = 1'b1;
         flit_o[X_HI:X_LO]  = x_cur - OFF_W'(1);
      end else if (x_neg) begin
         dest_oh_o[PORT_W]  = 1'b1;
         flit_o[X_HI:X_LO]  = x_cur + OFF_W'(1);
      end else if (y_pos) begin
         dest_oh_o[PORT_N]  = 1'b1;
         flit_o[Y_HI:0]     = y_cur - OFF_W'(1);
      end else if (y_neg) begin
         dest_oh_o[PORT_S]  = 1'b1;
         flit_o[Y_HI:0]     = y_cur + OFF_W'(1);
      end else begin
         dest_oh_o[PORT_LOCAL] = 1'b1;
      end
      if (kind != FK_HEAD) flit_o = flit_i;
   end
endmodule

// File: rtl/mr_rr_arbiter.sv
module mr_rr_arbiter #(
   parameter int N = 5,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req_i,
   input  logic             adv_i,
   output logic [N-1:0]     gnt_o,
   output logic [IDX_W-1:0] gnt_idx_o
);
   logic [IDX_W-1:0] ptr_q;
   logic             found;

   always_comb begin
      gnt_o     = '0;
      gnt_idx_o = '0;
      found     = 1'b0;
      for (int k = 0; k < N; k++) begin
         int idx;
         idx = int'(ptr_q) + k;
         if (idx >= N) idx = idx - N;
         if (!found && req_i[idx]) begin
            found      = 1'b1;
            gnt_o[idx] = 1'b1;
            gnt_idx_o  = IDX_W'(idx);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (adv_i && found) begin
         if (gnt_idx_o == IDX_W'(N - 1)) ptr_q <= '0;
         else                            ptr_q <= gnt_idx_o + IDX_W'(1);
      end
   end
endmodule

// File: rtl/mr_out_port.sv
module mr_out_port
   import mesh_router_pkg::*;
#(
   parameter int              NUM_IN   = 5,
   parameter int              FLIT_W   = 18,
   parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
   parameter logic [CRC_W-1:0] CRC_SEED = 16'hFFFF,
   localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_IN-1:0]             in_valid_i,
   input  logic [NUM_IN-1:0][FLIT_W-1:0] in_flit_i,
   input  logic [NUM_IN-1:0]             head_req_i,
   input  logic                          out_ready_i,
   output logic                          out_valid_o,
   output logic [FLIT_W-1:0]             out_flit_o,
   output logic [NUM_IN-1:0]             conn_o,
   output logic                          locked_o
);
   logic             lock_q;
   logic [IDX_W-1:0] owner_q;
   logic [CRC_W-1:0] crc_q;

   logic [NUM_IN-1:0] arb_req, arb_gnt;
   logic [IDX_W-1:0]  arb_idx, sel;
   logic [FLIT_W-1:0] raw;
   flit_kind_e        kind;
   logic              xfer;

   assign arb_req = lock_q ? '0 : head_req_i;

   mr_rr_arbiter #(.N(NUM_IN)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (arb_req),
      .adv_i     (out_ready_i),
      .gnt_o     (arb_gnt),
      .gnt_idx_o (arb_idx)
   );

   always_comb begin
      if (lock_q) begin
         sel         = owner_q;
         conn_o      = '0;
         conn_o[owner_q] = 1'b1;
         out_valid_o = in_valid_i[owner_q];
      end else begin
         sel         = arb_idx;
         conn_o      = arb_gnt;
         out_valid_o = |head_req_i;
      end
   end

   assign raw  = in_flit_i[sel];
   assign kind = flit_kind_e'(raw[FLIT_W-1 -: KIND_W]);
   assign xfer = out_valid_o && out_ready_i;

   always_comb begin
      out_flit_o = raw;
      if (kind == FK_TAIL) out_flit_o[CRC_W-1:0] = crc_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_q  <= 1'b0;
         owner_q <= '0;
         crc_q   <= CRC_SEED;
      end else if (xfer) begin
         if (!lock_q) begin
            lock_q  <= 1'b1;
            owner_q <= sel;
            crc_q   <= crc_chunk(CRC_SEED, raw[CRC_W-1:0], CRC_POLY);
         end else if (kind == FK_TAIL) begin
            lock_q  <= 1'b0;
            crc_q   <= CRC_SEED;
         end else begin
            crc_q   <= crc_chunk(crc_q, raw[CRC_W-1:0], CRC_POLY);
         end
      end
   end

   assign locked_o = lock_q;
endmodule

// File: rtl/mesh_router.sv
module mesh_router
   import mesh_router_pkg::*;
#(
   parameter int               DATA_W   = 16,
   parameter int               OFF_W    = 4,
   parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
   parameter logic [CRC_W-1:0] CRC_SEED = 16'hFFFF,
   localparam int FLIT_W = DATA_W + KIND_W,
   localparam int NP     = NUM_PORTS
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NP-1:0]             in_valid,
   input  logic [NP-1:0][FLIT_W-1:0] in_flit,
   output logic [NP-1:0]             in_ready,
   output logic [NP-1:0]             out_valid,
   output logic [NP-1:0][FLIT_W-1:0] out_flit,
   input  logic [NP-1:0]             out_ready
);
   if (DATA_W < CRC_W) begin : g_bad_data_w
      $error("mesh_router: DATA_W must hold the check word");
   end
   if (2 * OFF_W > CRC_W) begin : g_bad_off_w
      $error("mesh_router: offsets must fit in the hashed header bits");
   end
   if (OFF_W < 2) begin : g_bad_off_min
      $error("mesh_router: OFF_W must be at least 2");
   end

   logic [NP-1:0][NP-1:0]     dest_oh;   // [input][output]
   logic [NP-1:0][FLIT_W-1:0] fwd_flit;
   logic [NP-1:0][NP-1:0]     head_req;  // [output][input]
   logic [NP-1:0][NP-1:0]     conn;      // [output][input]
   logic [NP-1:0]             out_lock;

   for (genvar i = 0; i < NP; i++) begin : g_in
      mr_route_calc #(.FLIT_W(FLIT_W), .OFF_W(OFF_W)) u_route (
         .flit_i    (in_flit[i]),
         .dest_oh_o (dest_oh[i]),
         .flit_o    (fwd_flit[i])
      );
   end

   always_comb begin
      for (int o = 0; o < NP; o++) begin
         for (int i = 0; i < NP; i++) begin
            head_req[o][i] = in_valid[i] && dest_oh[i][o] &&
               (in_flit[i][FLIT_W-1 -: KIND_W] == FK_HEAD);
         end
      end
   end

   for (genvar o = 0; o < NP; o++) begin : g_out
      mr_out_port #(
         .NUM_IN   (NP),
         .FLIT_W   (FLIT_W),
         .CRC_POLY (CRC_POLY),
         .CRC_SEED (CRC_SEED)
      ) u_port (
         .clk         (clk),
         .rst_n       (rst_n),
         .in_valid_i  (in_valid),
         .in_flit_i   (fwd_flit),
         .head_req_i  (head_req[o]),
         .out_ready_i (out_ready[o]),
         .out_valid_o (out_valid[o]),
         .out_flit_o  (out_flit[o]),
         .conn_o      (conn[o]),
         .locked_o    (out_lock[o])
      );
   end

   always_comb begin
      for (int i = 0; i < NP; i++) begin
         in_ready[i] = 1'b0;
         for (int o = 0; o < NP; o++) begin
            in_ready[i] = in_ready[i] | (conn[o][i] & out_ready[o]);
         end
      end
   end
endmodule

// File: rtl/mr_checker.sv
module mr_checker
   import mesh_router_pkg::*;
#(
   parameter int NP     = 5,
   parameter int FLIT_W = 18,
   parameter int OFF_W  = 4
)(
   input logic                      clk,
   input logic                      rst_n,
   input logic [NP-1:0]             in_valid,
   input logic [NP-1:0]             in_ready,
   input logic [NP-1:0]             out_valid,
   input logic [NP-1:0][FLIT_W-1:0] out_flit,
   input logic [NP-1:0]             out_ready,
   input logic [NP-1:0]             out_lock
);
   localparam logic [KIND_W-1:0] K_HEAD = FK_HEAD;
   localparam logic [KIND_W-1:0] K_TAIL = FK_TAIL;

   function automatic logic is_head(input logic [FLIT_W-1:0] f);
      return f[FLIT_W-1 -: KIND_W] == K_HEAD;
   endfunction

   // R4: local delivery only at zero offsets
   a_r4_local_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[PORT_LOCAL] && is_head(out_flit[PORT_LOCAL])) |->
      (out_flit[PORT_LOCAL][2*OFF_W-1:0] == '0));

   // R3: Y ports only carry heads whose X is already zero
   a_r3_north_x_done: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[PORT_N] && is_head(out_flit[PORT_N])) |->
      (out_flit[PORT_N][2*OFF_W-1:OFF_W] == '0));
   a_r3_south_x_done: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[PORT_S] && is_head(out_flit[PORT_S])) |->
      (out_flit[PORT_S][2*OFF_W-1:OFF_W] == '0));

   // R2: east never sees a negative X after the step, west never a positive one
   a_r2_east_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[PORT_E] && is_head(out_flit[PORT_E])) |->
      !out_flit[PORT_E][2*OFF_W-1]);
   a_r2_west_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[PORT_W] && is_head(out_flit[PORT_W])) |->
      (out_flit[PORT_W][2*OFF_W-1] || (out_flit[PORT_W][2*OFF_W-1:OFF_W] == '0)));

   // R9: inputs accepted never outnumber outputs that move
   a_r9_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(in_valid & in_ready) <= $countones(out_valid & out_ready));

   for (genvar o = 0; o < NP; o++) begin : g_port
      // R5: a held output stays held until its tail moves
      a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (out_lock[o] && !(out_valid[o] && out_ready[o] &&
          out_flit[o][FLIT_W-1 -: KIND_W] == K_TAIL)) |=> out_lock[o]);
      // R5: the tail frees the output
      a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
         (out_lock[o] && out_valid[o] && out_ready[o] &&
          out_flit[o][FLIT_W-1 -: KIND_W] == K_TAIL) |=> !out_lock[o]);
      // R9: a stalled flit holds (upstream holds its inputs)
      a_r9_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid[o] && !out_ready[o]) |=> $stable(out_flit[o]));
   end
endmodule

bind mesh_router mr_checker #(.NP(NP), .FLIT_W(FLIT_W), .OFF_W(OFF_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_flit  (out_flit),
   .out_ready (out_ready),
   .out_lock  (out_lock)
);

// File: tb/mesh_router_test.sv
`timescale 1ns/1ps
module mesh_router_test;
   localparam int NP = 5;
   localparam int FW = 18;

   logic                  clk = 1'b0;
   logic                  rst_n;
   logic [NP-1:0]         in_valid, in_ready, out_valid, out_ready;
   logic [NP-1:0][FW-1:0] in_flit, out_flit;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   mesh_router uut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_flit(in_flit), .in_ready(in_ready),
      .out_valid(out_valid), .out_flit(out_flit), .out_ready(out_ready)
   );

   function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [15:0] d);
      logic [15:0] r = c;
      for (int b = 15; b >= 0; b--) begin
         logic top = r[15] ^ d[b];
         r = r << 1;
         if (top) r = r ^ 16'h1021;
      end
      return r;
   endfunction

   function automatic logic [15:0] hw(input logic [7:0] up, input logic [3:0] x, input logic [3:0] y);
      return {up, x, y};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      in_valid  = '0;
      in_flit   = '0;
      out_ready = '1;
      rst_n     = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic send_pkt(input int src, input int dst, input logic [15:0] h_in,
                           input logic [15:0] h_exp, input logic [15:0] body, input string tag);
      logic [15:0] crc;
      @(negedge clk);
      in_valid[src] = 1'b1;
      in_flit[src]  = {2'b01, h_in};
      #1;
      chk({tag, " head valid"}, 32'(out_valid[dst]), 32'd1);
      chk({tag, " head rewrite R8"}, 32'(out_flit[dst]), 32'({2'b01, h_exp}));
      chk({tag, " head accepted"}, 32'(in_ready[src]), 32'd1);
      crc = crc_ref(16'hFFFF, h_exp);
      @(negedge clk);
      in_flit[src] = {2'b00, body};
      #1;
      chk({tag, " body follows R5"}, 32'(out_flit[dst]), 32'({2'b00, body}));
      crc = crc_ref(crc, body);
      @(negedge clk);
      in_flit[src] = {2'b10, 16'h0000};
      #1;
      chk({tag, " tail crc R6"}, 32'(out_flit[dst]), 32'({2'b10, crc}));
      @(negedge clk);
      in_valid[src] = 1'b0;
      in_flit[src]  = '0;
      #1;
      chk({tag, " released R5"}, 32'(out_valid[dst]), 32'd0);
   endtask

   task automatic t_reset();
      #1;
      chk("R1 out_valid idle", 32'(out_valid), 32'd0);
      chk("R1 in_ready idle", 32'(in_ready), 32'd0);
   endtask

   task automatic t_east();  // R2
      send_pkt(0, 2, hw(8'hA5, 4'h3, 4'hE), hw(8'hA5, 4'h2, 4'hE), 16'h1234, "R2 east");
   endtask

   task automatic t_west();  // R2
      send_pkt(0, 4, hw(8'h5A, 4'h8, 4'h3), hw(8'h5A, 4'h9, 4'h3), 16'hBEEF, "R2 west");
   endtask

   task automatic t_north(); // R3
      send_pkt(4, 1, hw(8'h01, 4'h0, 4'h5), hw(8'h01, 4'h0, 4'h4), 16'h0F0F, "R3 north");
   endtask

   task automatic t_south(); // R3
      send_pkt(1, 3, hw(8'hC3, 4'h0, 4'hF), hw(8'hC3, 4'h0, 4'h0), 16'hFFFF, "R3 south");
   endtask

   task automatic t_local(); // R4
      send_pkt(3, 0, hw(8'h77, 4'h0, 4'h0), hw(8'h77, 4'h0, 4'h0), 16'h8001, "R4 local");
   endtask

   task automatic t_rr();    // R7 and R5
      do_reset();
      @(negedge clk);
      in_valid[1] = 1'b1; in_flit[1] = {2'b01, hw(8'h11, 4'h1, 4'h0)};
      in_valid[3] = 1'b1; in_flit[3] = {2'b01, hw(8'h33, 4'h1, 4'h0)};
      #1;
      chk("R7 first grant in1", 32'(in_ready[1]), 32'd1);
      chk("R7 in3 waits", 32'(in_ready[3]), 32'd0);
      chk("R7 winner flit", 32'(out_flit[2][15:8]), 32'h11);
      @(negedge clk);
      in_flit[1] = {2'b00, 16'h2222};
      #1;
      chk("R5 head blocked mid-packet", 32'(in_ready[3]), 32'd0);
      @(negedge clk);
      in_flit[1] = {2'b10, 16'h0};
      #1;
      chk("R5 still blocked at tail", 32'(in_ready[3]), 32'd0);
      @(negedge clk);
      in_valid[1] = 1'b0;
      #1;
      chk("R7 in3 granted next", 32'(in_ready[3]), 32'd1);
      chk("R7 in3 flit", 32'(out_flit[2][15:8]), 32'h33);
      @(negedge clk);
      in_flit[3] = {2'b10, 16'h0};
      in_valid[0] = 1'b1; in_flit[0] = {2'b01, hw(8'h00, 4'h2, 4'h0)};
      in_valid[1] = 1'b1; in_flit[1] = {2'b01, hw(8'h10, 4'h2, 4'h0)};
      #1;
      chk("R5 heads wait for tail in0", 32'(in_ready[0]), 32'd0);
      chk("R5 heads wait for tail in1", 32'(in_ready[1]), 32'd0);
      @(negedge clk);
      in_valid[3] = 1'b0;
      #1;
      chk("R7 pointer wraps to in0", 32'(in_ready[0]), 32'd1);
      chk("R7 in1 loses after wrap", 32'(in_ready[1]), 32'd0);
      @(negedge clk);
      in_flit[0] = {2'b10, 16'h0};
      @(negedge clk);
      in_valid[0] = 1'b0;
      #1;
      chk("R7 in1 follows in0", 32'(in_ready[1]), 32'd1);
      @(negedge clk);
      in_flit[1] = {2'b10, 16'h0};
      @(negedge clk);
      in_valid = '0;
      in_flit  = '0;
   endtask

   task automatic t_stall(); // R9 and R6
      logic [15:0] h_exp;
      h_exp = hw(8'h9C, 4'h0, 4'h2);
      @(negedge clk);
      out_ready[2] = 1'b0;
      in_valid[0] = 1'b1;
      in_flit[0]  = {2'b01, hw(8'h9C, 4'h1, 4'h2)};
      #1;
      chk("R9 stalled valid", 32'(out_valid[2]), 32'd1);
      chk("R9 stalled not ready", 32'(in_ready[0]), 32'd0);
      @(negedge clk);
      #1;
      chk("R9 flit held", 32'(out_flit[2]), 32'({2'b01, h_exp}));
      out_ready[2] = 1'b1;
      #1;
      chk("R9 ready follows out_ready", 32'(in_ready[0]), 32'd1);
      @(negedge clk);
      in_flit[0]   = {2'b10, 16'h0};
      out_ready[2] = 1'b0;
      @(negedge clk);
      #1;
      chk("R9 tail held in0 not ready", 32'(in_ready[0]), 32'd0);
      out_ready[2] = 1'b1;
      #1;
      chk("R6 crc over head only after stalls", 32'(out_flit[2]),
          32'({2'b10, crc_ref(16'hFFFF, h_exp)}));
      @(negedge clk);
      in_valid = '0;
      in_flit  = '0;
   endtask

   task automatic t_parallel(); // R10
      @(negedge clk);
      in_valid[0] = 1'b1; in_flit[0] = {2'b01, hw(8'hE0, 4'h2, 4'h0)};
      in_valid[2] = 1'b1; in_flit[2] = {2'b01, hw(8'hE2, 4'h0, 4'h0)};
      #1;
      chk("R10 east accepts", 32'(in_ready[0]), 32'd1);
      chk("R10 local accepts", 32'(in_ready[2]), 32'd1);
      chk("R10 both outputs valid", 32'({out_valid[2], out_valid[0]}), 32'b11);
      @(negedge clk);
      in_flit[0] = {2'b10, 16'h0};
      in_flit[2] = {2'b10, 16'h0};
      #1;
      chk("R10 east tail", 32'(out_flit[2]),
          32'({2'b10, crc_ref(16'hFFFF, hw(8'hE0, 4'h1, 4'h0))}));
      chk("R10 local tail", 32'(out_flit[0]),
          32'({2'b10, crc_ref(16'hFFFF, hw(8'hE2, 4'h0, 4'h0))}));
      @(negedge clk);
      in_valid = '0;
      in_flit  = '0;
   endtask

   initial begin
      #(5.0 * 100000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      do_reset();
      t_reset();
      t_east();
      t_west();
      t_north();
      t_south();
      t_local();
      t_rr();
      t_stall();
      t_parallel();
      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule